// File: doc/BRIEF.md
# Masked Register Sequence Generator

This block turns a register-selection bitmask into a stream of register numbers for a save or restore sequence. The mask arrives as data, so the length of the operation is known only at run time. The mask may have gaps between its set bits. The generator emits one selected register number per clock cycle in ascending order, and it spends no cycles on the unset bits between them. Each number goes to a register-file port as a valid-qualified index.

A population count of the mask gives the total transfer count, which is available from the first cycle of the sequence. Register 0 is hardwired, so it never appears in the output. A consumer-side ready input can stall the stream. A pending interrupt ends the sequence at the next register boundary. On an abort the untransferred part of the mask is left visible, so software can restart the operation with it as the new mask.

Top module: `regseq_gen`

## Requirements
- R1: While idle, a cycle with `start_i` high captures `mask_i` with bit 0 forced to zero. If any bit remains, `busy_o` is high from the next cycle until the cycle of the last transfer.
- R2: The indices on `index_o` while `valid_o` is high are exactly the set bits of the captured mask, each once, in strictly ascending order.
- R3: Index 0 is never presented with `valid_o` high, even when bit 0 of `mask_i` is set.
- R4: With `ready_i` held high, `valid_o` is high on every busy cycle, whatever the gaps between set bits. A transfer takes place on each clock edge where `valid_o` and `ready_i` are both high. `done_o` is a one-cycle pulse in the cycle after the last transfer, and `busy_o` is low during that pulse.
- R5: From the cycle after start, `total_o` equals the number of set bits in `mask_i[63:1]` at start. It holds that value until the next accepted start.
- R6: A start whose mask has no set bit above bit 0 raises `done_o` in the next cycle. It produces no `valid_o` and no `busy_o`.
- R7: While `ready_i` is low, `valid_o` and `index_o` hold their values and no register is consumed.
- R8: When `irq_pend_i` is high in a busy cycle, `valid_o` is low in that cycle. In the next cycle `done_o` and `aborted_o` pulse together and `busy_o` is low.
- R9: `remain_o` always shows the captured bits that have not yet been transferred. After an abort it holds them until the next accepted start.
- R10: `start_i` is ignored while `busy_o` is high.
- R11: After reset, `busy_o`, `valid_o`, `done_o`, `aborted_o`, `remain_o` and `total_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a sequence with `mask_i` (idle only) |
| mask_i | input | 64 | Register-selection mask |
| ready_i | input | 1 | Consumer accepts the presented index |
| irq_pend_i | input | 1 | Interrupt pending; ends the sequence at the next boundary |
| valid_o | output | 1 | `index_o` holds a register to transfer |
| index_o | output | 6 | Register number |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| aborted_o | output | 1 | Pulses with `done_o` when an interrupt ended the sequence |
| total_o | output | 7 | Transfer count of the captured mask |
| remain_o | output | 64 | Untransferred part of the captured mask |

## Verification
The bench sends masks with sparse holes, adjacent runs, a fully set mask and masks that touch only bit 0 or bit 63. A generator that idled on holes would show a gap in `valid_o`. One that emitted register 0 would show it in the index stream, and one with an off-by-one finish would move the `done_o` pulse. A consumer stall is held over several cycles, which exposes any design that skips or repeats an index. An interrupt is raised mid-sequence and the run is then resumed from `remain_o`, which catches a design that loses the register it was presenting or keeps emitting after the abort. A start raised while busy must not disturb the sequence in progress.

// File: rtl/regseq_pkg.sv
// Package: shared types of the masked register sequence generator.
// Assumes nothing beyond a single clock domain.
package regseq_pkg;

    // Sequencer control states.
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

endpackage : regseq_pkg

// File: rtl/regseq_popcnt.sv
// Module: regseq_popcnt
// Counts the set bits of a vector. Purely combinational.
// Assumes CNT_W is wide enough to hold W.
module regseq_popcnt #(
    parameter int W     = 64,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec_i,
    output logic [CNT_W-1:0] cnt_o
);

    // Sum each bit into the count.
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CNT_W'(vec_i[i]);
        end
    end

endmodule : regseq_popcnt

// File: rtl/regseq_prienc.sv
// Module: regseq_prienc
// Finds the lowest set bit of a vector and returns it both as a one-hot
// vector and as a binary index. Combinational, no idle cycles.
// Assumes W is a power of two; the index is don't-care when found_o is low.
module regseq_prienc #(
    parameter int W     = 64,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec_i,
    output logic [W-1:0]     onehot_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             found_o
);

    // Isolate the lowest set bit with the two's-complement trick.
    always_comb begin
        onehot_o = vec_i & ((~vec_i) + W'(1));
        found_o  = |vec_i;
    end

    // Each index bit is the OR of the one-hot lines whose position has it set.
    for (genvar b = 0; b < IDX_W; b++) begin : g_idx_bit
        logic [W-1:0] sel;
        for (genvar i = 0; i < W; i++) begin : g_sel
            if (((i >> b) & 1) == 1) begin : g_on
                assign sel[i] = onehot_o[i];
            end else begin : g_off
                assign sel[i] = 1'b0;
            end
        end
        assign idx_o[b] = |sel;
    end

endmodule : regseq_prienc

// File: rtl/regseq_ctrl.sv
// Module: regseq_ctrl
// Control of the sequence: captures the mask on start, clears one bit
// per accepted transfer, finishes or aborts, and keeps the working mask.
// Assumes the caller has already cleared bit 0 of the start mask and
// supplies the lowest-bit one-hot of the working mask.
module regseq_ctrl
    import regseq_pkg::*;
#(
    parameter int W     = 64,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [W-1:0]     mask_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             ready_i,
    input  logic             irq_i,
    input  logic [W-1:0]     low_onehot_i,
    input  logic             found_i,
    output logic [W-1:0]     work_o,
    output logic [CNT_W-1:0] total_o,
    output logic             busy_o,
    output logic             valid_o,
    output logic             done_o,
    output logic             aborted_o
);

    seq_state_t       state_q;
    logic [W-1:0]     work_q;
    logic [CNT_W-1:0] total_q;
    logic             done_q;
    logic             abort_q;
    logic             take;
    logic             last;

    // Transfer qualification and last-register detection.
    always_comb begin
        valid_o = (state_q == SEQ_RUN) && found_i && !irq_i;
        take    = valid_o && ready_i;
        last    = (work_q == low_onehot_i);
    end

    // Sequencer state, working mask and end-of-sequence flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            work_q  <= '0;
            total_q <= '0;
            done_q  <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            abort_q <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        work_q  <= mask_i;
                        total_q <= cnt_i;
                        if (mask_i == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            state_q <= SEQ_RUN;
                        end
                    end
                end
                SEQ_RUN: begin
                    if (irq_i) begin
                        state_q <= SEQ_IDLE;
                        done_q  <= 1'b1;
                        abort_q <= 1'b1;
                    end else if (!found_i) begin
                        state_q <= SEQ_IDLE;
                        done_q  <= 1'b1;
                    end else if (take) begin
                        work_q <= work_q & ~low_onehot_i;
                        if (last) begin
                            state_q <= SEQ_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Drive outputs from the registered state.
    always_comb begin
        work_o    = work_q;
        total_o   = total_q;
        busy_o    = (state_q == SEQ_RUN);
        done_o    = done_q;
        aborted_o = abort_q;
    end

endmodule : regseq_ctrl

// File: rtl/regseq_gen.sv
// Module: regseq_gen (top)
// Masked register sequence generator. Emits the selected register numbers
// of a mask, lowest first, one per cycle with no cycles lost on holes.
// Register 0 is hardwired and never emitted. An interrupt ends the
// sequence at a register boundary and leaves the rest in remain_o.
// Assumes MASK_W is a power of two.
module regseq_gen #(
    parameter int MASK_W = 64,
    localparam int IDX_W = $clog2(MASK_W),
    localparam int CNT_W = $clog2(MASK_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              ready_i,
    input  logic              irq_pend_i,
    output logic              valid_o,
    output logic [IDX_W-1:0]  index_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              aborted_o,
    output logic [CNT_W-1:0]  total_o,
    output logic [MASK_W-1:0] remain_o
);

    logic [MASK_W-1:0] start_mask;
    logic [CNT_W-1:0]  start_cnt;
    logic [MASK_W-1:0] work;
    logic [MASK_W-1:0] low_onehot;
    logic              found;

    // Drop the hardwired register 0 from the incoming mask.
    always_comb begin
        start_mask = mask_i & ~MASK_W'(1);
    end

    regseq_popcnt #(.W(MASK_W), .CNT_W(CNT_W)) u_popcnt (
        .vec_i (start_mask),
        .cnt_o (start_cnt)
    );

    regseq_prienc #(.W(MASK_W), .IDX_W(IDX_W)) u_prienc (
        .vec_i    (work),
        .onehot_o (low_onehot),
        .idx_o    (index_o),
        .found_o  (found)
    );

    regseq_ctrl #(.W(MASK_W), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mask_i       (start_mask),
        .cnt_i        (start_cnt),
        .ready_i      (ready_i),
        .irq_i        (irq_pend_i),
        .low_onehot_i (low_onehot),
        .found_i      (found),
        .work_o       (work),
        .total_o      (total_o),
        .busy_o       (busy_o),
        .valid_o      (valid_o),
        .done_o       (done_o),
        .aborted_o    (aborted_o)
    );

    // Expose the untransferred part of the mask.
    always_comb begin
        remain_o = work;
    end

endmodule : regseq_gen

// File: rtl/regseq_gen_chk.sv
// Module: regseq_gen_chk
// Temporal checks on the ports of regseq_gen, attached with bind.
module regseq_gen_chk #(
    parameter int MASK_W = 64,
    localparam int IDX_W = $clog2(MASK_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready_i,
    input logic              irq_pend_i,
    input logic              valid_o,
    input logic [IDX_W-1:0]  index_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              aborted_o,
    input logic [MASK_W-1:0] remain_o
);

    assert_valid_in_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> busy_o);

    assert_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i) |=> (!valid_o || (index_o > $past(index_o))));

    assert_no_reg0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (index_o != '0));

    assert_one_per_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i) |=> ($countones(remain_o) + 1 == $countones($past(remain_o))));

    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> ($stable(index_o) && $stable(remain_o)));

    assert_irq_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && irq_pend_i) |-> !valid_o);

    assert_irq_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && irq_pend_i) |=> (aborted_o && done_o));

    assert_abort_pairs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        aborted_o |-> (done_o && !busy_o));

endmodule : regseq_gen_chk

bind regseq_gen regseq_gen_chk #(.MASK_W(MASK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_i    (ready_i),
    .irq_pend_i (irq_pend_i),
    .valid_o    (valid_o),
    .index_o    (index_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .aborted_o  (aborted_o),
    .remain_o   (remain_o)
);

// File: tb/regseq_gen_test.sv
module regseq_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] mask_i = '0;
    logic        ready_i = 1'b1;
    logic        irq_pend_i = 1'b0;
    logic        valid_o;
    logic [5:0]  index_o;
    logic        busy_o;
    logic        done_o;
    logic        aborted_o;
    logic [6:0]  total_o;
    logic [63:0] remain_o;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    regseq_gen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
        .ready_i(ready_i), .irq_pend_i(irq_pend_i), .valid_o(valid_o),
        .index_o(index_o), .busy_o(busy_o), .done_o(done_o),
        .aborted_o(aborted_o), .total_o(total_o), .remain_o(remain_o)
    );

    localparam int NVEC = 7;
    localparam logic [63:0] VEC [NVEC] = '{
        64'h0000_0000_0000_0002,
        64'h8000_0000_0000_0001,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'hA5A5_0F0F_3C3C_5A5B,
        64'h8000_0000_0000_0002,
        64'h0000_0001_0010_0100,
        64'h7000_0000_0000_000E
    };

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ones(input logic [63:0] v);
        int n = 0;
        for (int i = 0; i < 64; i++) n += int'(v[i]);
        return n;
    endfunction

    // Start a sequence and follow it to its end with ready high.
    task automatic run_seq(input logic [63:0] m);
        logic [63:0] rem;
        @(negedge clk);
        start_i = 1'b1;
        mask_i  = m;
        @(negedge clk);
        start_i = 1'b0;
        rem = m & ~64'd1;
        check(total_o == 7'(ones(rem)), "R5 total", 64'(total_o), 64'(ones(rem)));
        if (rem == '0) begin
            check(done_o && !busy_o && !valid_o, "R6 empty done",
                  {61'd0, done_o, busy_o, valid_o}, 64'd4);
            return;
        end
        check(busy_o, "R1 busy", 64'(busy_o), 64'd1);
        for (int b = 1; b < 64; b++) begin
            if (rem[b]) begin
                check(valid_o && index_o == 6'(b), "R2 R4 index",
                      {57'd0, valid_o, index_o}, 64'(64 + b));
                check(remain_o == rem, "R9 remain", remain_o, rem);
                rem[b] = 1'b0;
                @(negedge clk);
            end
        end
        check(done_o && !aborted_o && !busy_o && !valid_o, "R4 done",
              {60'd0, done_o, aborted_o, busy_o, valid_o}, 64'd8);
    endtask

    initial begin
        logic [5:0] seen;
        repeat (3) @(negedge clk);
        check(!busy_o && !valid_o && !done_o && !aborted_o && remain_o == '0 && total_o == '0,
              "R11 reset", remain_o, 64'd0);
        rst_n = 1'b1;

        // Table of masks.
        for (int v = 0; v < NVEC; v++) run_seq(VEC[v]);

        // R3 and R6: only bit 0 set.
        run_seq(64'h1);
        run_seq(64'h0);

        // R7: stall with ready low.
        @(negedge clk);
        start_i = 1'b1; mask_i = 64'h28; ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check(valid_o && index_o == 6'd3 && remain_o == 64'h28, "R7 stall hold",
                  {57'd0, valid_o, index_o}, 64'd67);
            @(negedge clk);
        end
        ready_i = 1'b1;
        check(valid_o && index_o == 6'd3, "R7 release", 64'(index_o), 64'd3);
        @(negedge clk);
        check(valid_o && index_o == 6'd5, "R7 next", 64'(index_o), 64'd5);
        @(negedge clk);
        check(done_o, "R4 done after stall", 64'(done_o), 64'd1);

        // R8 / R9: abort mid-sequence, then resume.
        @(negedge clk);
        start_i = 1'b1; mask_i = 64'h214;
        @(negedge clk);
        start_i = 1'b0;
        check(valid_o && index_o == 6'd2, "R2 first", 64'(index_o), 64'd2);
        @(negedge clk);
        irq_pend_i = 1'b1;
        #1;
        check(!valid_o, "R8 valid drops", 64'(valid_o), 64'd0);
        @(negedge clk);
        irq_pend_i = 1'b0;
        check(done_o && aborted_o && !busy_o, "R8 abort flags",
              {61'd0, done_o, aborted_o, busy_o}, 64'd6);
        check(remain_o == 64'h210, "R9 remain after abort", remain_o, 64'h210);
        @(negedge clk);
        check(remain_o == 64'h210 && !valid_o, "R9 remain held", remain_o, 64'h210);
        run_seq(remain_o);

        // R10: start while busy is ignored.
        @(negedge clk);
        start_i = 1'b1; mask_i = 64'h0010_0400;
        @(negedge clk);
        mask_i = 64'h4000_0000;   // start still high while busy
        check(index_o == 6'd10, "R10 first", 64'(index_o), 64'd10);
        @(negedge clk);
        start_i = 1'b0;
        check(valid_o && index_o == 6'd20, "R10 unaffected", 64'(index_o), 64'd20);
        @(negedge clk);
        seen = index_o;
        check(done_o && remain_o == '0 && total_o == 7'd2, "R10 no new capture",
              remain_o, 64'd0);
        @(negedge clk);
        check(!busy_o && !valid_o, "R10 idle", {62'd0, busy_o, valid_o}, 64'd0);

        // R8: interrupt while idle has no effect.
        irq_pend_i = 1'b1;
        @(negedge clk);
        check(!aborted_o && !done_o, "R8 idle irq", 64'(aborted_o), 64'd0);
        irq_pend_i = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule : regseq_gen_test